// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations so that a memory access can be translated in the same cycle it is presented. Every entry is compared against the incoming virtual page number in parallel. On a match the stored physical page number is joined with the page offset, which passes through unchanged. Each entry also carries read, write and dirty flags, and the access type is checked against them.

A lookup that finds no valid entry raises `miss`. An external page walker then resolves the translation and installs it through the refill port. New translations take slots in strict round-robin order. A refill whose page number is already resident rewrites that entry in place and uses no new slot. Entries hold no address-space identifier, so software pulses `flush` on a context switch to invalidate every entry.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid and the round-robin pointer is at slot 0, so any valid lookup gives `miss`=1, `hit`=0 and `protFault`=0.
- R2: When a lookup matches a valid entry and the access is permitted, `hit`=1 and `paddr` = {stored physical page, `lookupVaddr[11:0]`}. Both appear combinationally in the same cycle.
- R3: When `lookupValid`=1 and no valid entry holds the virtual page number `lookupVaddr[31:12]`, then `miss`=1, `hit`=0, `protFault`=0 and `paddr`=0. `hit` and `miss` are never both 1.
- R4: On a hit, `protFault`=1 when `lookupWrite`=1 (write) and the entry's write flag is 0, or when `lookupWrite`=0 (read) and its read flag is 0. In that case `hit` stays 1 and `paddr`=0. `protFault` is 0 whenever `hit` is 0.
- R5: On a hit, `pageDirty` equals the entry's dirty flag. Without a hit it is 0.
- R6: A refill installs its page numbers and flags (`refillPerm` bit 2 = read, bit 1 = write, bit 0 = dirty) at the clock edge. Lookups see the new entry from the next cycle onward.
- R7: Refills of page numbers that are not resident fill slots 0, 1, …, ENTRIES-1 in order and then wrap. The refill after a full set evicts the oldest allocated entry.
- R8: A refill whose virtual page number matches a valid entry overwrites that entry. No duplicate is created and the round-robin pointer does not advance.
- R9: `flush` invalidates every entry at the clock edge and returns the round-robin pointer to slot 0.
- R10: When `flush` and `refillValid` are high in the same cycle, the flush wins and the refill is dropped.
- R11: When `lookupValid`=0, `hit`, `miss`, `protFault` and `pageDirty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A translation is requested this cycle |
| lookupVaddr | input | VA_W (32) | Virtual address to translate |
| lookupWrite | input | 1 | 1 = write access, 0 = read access |
| hit | output | 1 | A valid entry matches the page number |
| miss | output | 1 | No valid entry matches; a page walk is needed |
| protFault | output | 1 | Matched entry denies the access type |
| pageDirty | output | 1 | Dirty flag of the matched entry |
| paddr | output | PA_W (32) | Translated physical address; 0 unless the access is permitted |
| refillValid | input | 1 | Install a translation at this edge |
| refillVpn | input | VA_W-12 (20) | Virtual page number to install |
| refillPpn | input | PA_W-12 (20) | Physical page number to install |
| refillPerm | input | 3 | {read, write, dirty} flags to install |
| flush | input | 1 | Invalidate all entries and reset the pointer |

## Verification
The hardest situation to reach is a rewrite of a resident page while the buffer is full and the round-robin pointer sits mid-way. Only the identity of the next victim shows that the pointer was held. A directed sequence fills all slots, rewrites one resident page, and then allocates a new page while probing which older page vanished. Constrained random refills drawn from a page pool about half again larger than the entry count keep the buffer at capacity with frequent wraparound and resident rewrites. A bench-side reference model tracks slot contents, pointer position and permissions.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Strobes sent from control to the entry store.
  typedef struct packed {
    logic clearAll;
    logic writeEn;
  } xlatStrobe_t;

  // Flags stored with every translation.
  typedef struct packed {
    logic rd;
    logic wr;
    logic dirty;
  } pagePerm_t;

endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  xlatStrobe_t      strobe,
  input  logic [IDX_W-1:0] writeIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PPN_W-1:0] wrPpn,
  input  pagePerm_t        wrPerm,
  input  logic [VPN_W-1:0] lkVpn,
  output logic             lkMatchAny,
  output logic [PPN_W-1:0] lkPpn,
  output pagePerm_t        lkPerm,
  output logic             rfMatchAny,
  output logic [IDX_W-1:0] rfMatchIdx
);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [PPN_W-1:0]   ppnQ  [ENTRIES];
  pagePerm_t          permQ [ENTRIES];
  logic [ENTRIES-1:0] lkHitVec;
  logic [ENTRIES-1:0] rfHitVec;

  // Per-slot storage and parallel comparators.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        vpnQ[i]   <= '0;
        ppnQ[i]   <= '0;
        permQ[i]  <= '0;
      end else if (strobe.clearAll) begin
        validQ[i] <= 1'b0;
      end else if (strobe.writeEn && (writeIdx == IDX_W'(i))) begin
        validQ[i] <= 1'b1;
        vpnQ[i]   <= wrVpn;
        ppnQ[i]   <= wrPpn;
        permQ[i]  <= wrPerm;
      end
    end

    assign lkHitVec[i] = validQ[i] && (vpnQ[i] == lkVpn);
    assign rfHitVec[i] = validQ[i] && (vpnQ[i] == wrVpn);
  end

  // OR-combine the matched slot (at most one matches).
  always_comb begin
    lkPpn  = '0;
    lkPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkHitVec[i]) begin
        lkPpn  = lkPpn | ppnQ[i];
        lkPerm = lkPerm | permQ[i];
      end
    end
  end

  always_comb begin
    rfMatchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rfHitVec[i]) rfMatchIdx = IDX_W'(i);
    end
  end

  assign lkMatchAny = |lkHitVec;
  assign rfMatchAny = |rfHitVec;

  AST_NO_DUP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec)) else $error("duplicate resident page");  // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (validQ == '0)) else $error("flush left a valid entry");  // R9

endmodule

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             refillValid,
  input  logic             rfMatchAny,
  input  logic [IDX_W-1:0] rfMatchIdx,
  output xlatStrobe_t      strobe,
  output logic [IDX_W-1:0] writeIdx
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] victimPtr;
  logic             allocNew;

  assign strobe.clearAll = flush;
  assign strobe.writeEn  = refillValid && !flush;
  assign allocNew        = strobe.writeEn && !rfMatchAny;
  assign writeIdx        = rfMatchAny ? rfMatchIdx : victimPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimPtr <= '0;
    end else if (flush) begin
      victimPtr <= '0;
    end else if (allocNew) begin
      victimPtr <= (victimPtr == LAST_SLOT) ? '0 : victimPtr + 1'b1;
    end
  end

  AST_PTR_HOLD_ON_REWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !flush && rfMatchAny) |=> $stable(victimPtr))
    else $error("pointer moved on rewrite");  // R8

  AST_PTR_ZERO_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (victimPtr == '0)) else $error("pointer not reset by flush");  // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !flush && !rfMatchAny) |=>
      (victimPtr == (($past(victimPtr) == LAST_SLOT) ? '0 : $past(victimPtr) + 1'b1)))
    else $error("pointer did not step");  // R7

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVaddr,
  input  logic             lookupWrite,
  output logic             hit,
  output logic             miss,
  output logic             protFault,
  output logic             pageDirty,
  output logic [PA_W-1:0]  paddr,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PPN_W-1:0] refillPpn,
  input  logic [2:0]       refillPerm,
  input  logic             flush
);

  xlatStrobe_t      strobe;
  logic [IDX_W-1:0] writeIdx;
  logic             lkMatchAny;
  logic [PPN_W-1:0] lkPpn;
  pagePerm_t        lkPerm;
  logic             rfMatchAny;
  logic [IDX_W-1:0] rfMatchIdx;
  pagePerm_t        wrPerm;
  logic             denied;

  assign wrPerm = pagePerm_t'(refillPerm);

  xlat_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .refillValid(refillValid),
    .rfMatchAny (rfMatchAny),
    .rfMatchIdx (rfMatchIdx),
    .strobe     (strobe),
    .writeIdx   (writeIdx)
  );

  xlat_datapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .writeIdx  (writeIdx),
    .wrVpn     (refillVpn),
    .wrPpn     (refillPpn),
    .wrPerm    (wrPerm),
    .lkVpn     (lookupVaddr[VA_W-1:OFF_W]),
    .lkMatchAny(lkMatchAny),
    .lkPpn     (lkPpn),
    .lkPerm    (lkPerm),
    .rfMatchAny(rfMatchAny),
    .rfMatchIdx(rfMatchIdx)
  );

  assign denied    = lookupWrite ? !lkPerm.wr : !lkPerm.rd;
  assign hit       = lookupValid && lkMatchAny;
  assign miss      = lookupValid && !lkMatchAny;
  assign protFault = hit && denied;
  assign pageDirty = hit && lkPerm.dirty;
  assign paddr     = (hit && !denied) ? {lkPpn, lookupVaddr[OFF_W-1:0]} : '0;

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && miss)) else $error("hit and miss together");  // R3

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> hit) else $error("fault without hit");  // R4

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !protFault) |-> (paddr[OFF_W-1:0] == lookupVaddr[OFF_W-1:0]))
    else $error("offset altered");  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hit || miss || protFault || pageDirty))
    else $error("activity without lookup");  // R11

endmodule

// File: tb/xlat_buffer_tb.sv
module xlat_buffer_tb;

  localparam int N = 32;
  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid;
  logic [31:0] lookupVaddr;
  logic        lookupWrite;
  logic        hit, miss, protFault, pageDirty;
  logic [31:0] paddr;
  logic        refillValid;
  logic [19:0] refillVpn, refillPpn;
  logic [2:0]  refillPerm;
  logic        flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic        mValid [N];
  logic [19:0] mVpn   [N];
  logic [19:0] mPpn   [N];
  logic [2:0]  mPerm  [N];
  int          mPtr;

  always #(PERIOD/2) clk = ~clk;

  xlat_buffer u_dut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVaddr(lookupVaddr), .lookupWrite(lookupWrite),
    .hit(hit), .miss(miss), .protFault(protFault), .pageDirty(pageDirty), .paddr(paddr),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPpn(refillPpn),
    .refillPerm(refillPerm), .flush(flush)
  );

  function automatic int modelFind(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == vpn) return i;
    return -1;
  endfunction

  // Expected {hit, miss, fault, dirty, paddr}
  function automatic logic [35:0] modelLookup(input logic lv, input logic [31:0] va,
                                              input logic lw);
    int idx;
    logic h, f, d;
    logic [31:0] pa;
    if (!lv) return '0;
    idx = modelFind(va[31:12]);
    if (idx < 0) return {1'b0, 1'b1, 1'b0, 1'b0, 32'h0};
    h = 1'b1;
    f = lw ? !mPerm[idx][1] : !mPerm[idx][2];
    d = mPerm[idx][0];
    pa = f ? 32'h0 : {mPpn[idx], va[11:0]};
    return {h, 1'b0, f, d, pa};
  endfunction

  task automatic modelUpdate(input logic rv, input logic [19:0] vpn, input logic [19:0] ppn,
                             input logic [2:0] perm, input logic fl);
    int idx;
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
      mPtr = 0;
    end else if (rv) begin
      idx = modelFind(vpn);
      if (idx < 0) begin
        idx = mPtr;
        mPtr = (mPtr + 1) % N;
      end
      mValid[idx] = 1'b1; mVpn[idx] = vpn; mPpn[idx] = ppn; mPerm[idx] = perm;
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, clock, update model.
  task automatic step(input logic lv, input logic [31:0] va, input logic lw,
                      input logic rv, input logic [19:0] rvpn, input logic [19:0] rppn,
                      input logic [2:0] rperm, input logic fl, input string tag);
    logic [35:0] exp, act;
    @(negedge clk);
    lookupValid = lv; lookupVaddr = va; lookupWrite = lw;
    refillValid = rv; refillVpn = rvpn; refillPpn = rppn; refillPerm = rperm; flush = fl;
    #2;
    exp = modelLookup(lv, va, lw);
    act = {hit, miss, protFault, pageDirty, paddr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: va=%h wr=%0b actual hit/miss/fault/dirty=%b paddr=%h expected %b paddr=%h",
               tag, va, lw, act[35:32], act[31:0], exp[35:32], exp[31:0]);
    end
    @(posedge clk);
    modelUpdate(rv, rvpn, rppn, rperm, fl);
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic lw,
                      input string tag);
    step(1'b1, {vpn, off}, lw, 1'b0, '0, '0, '0, 1'b0, tag);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] perm,
                      input string tag);
    step(1'b0, '0, 1'b0, 1'b1, vpn, ppn, perm, 1'b0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7919));
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mVpn[i] = 0; mPpn[i] = 0; mPerm[i] = 0; end
    mPtr = 0;
    rstN = 0; lookupValid = 0; lookupVaddr = 0; lookupWrite = 0;
    refillValid = 0; refillVpn = 0; refillPpn = 0; refillPerm = 0; flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: empty after reset
    look(20'h00000, 12'h000, 1'b0, "R1 reset miss");
    look(20'h00005, 12'h123, 1'b1, "R1 reset miss write");

    // R6/R2: install then translate
    fill(20'h00005, 20'hABCDE, 3'b110, "R6 fill");
    look(20'h00005, 12'h7F3, 1'b0, "R2 read hit");
    look(20'h00005, 12'h001, 1'b1, "R2 write hit");
    look(20'h00006, 12'h001, 1'b0, "R3 neighbour miss");

    // R4: permissions
    fill(20'h00010, 20'h11111, 3'b100, "R6 fill ro");
    look(20'h00010, 12'h040, 1'b1, "R4 write to read-only");
    look(20'h00010, 12'h040, 1'b0, "R4 read of read-only");
    fill(20'h00011, 20'h22222, 3'b010, "R6 fill wo");
    look(20'h00011, 12'hFFF, 1'b0, "R4 read of write-only");
    // R5: dirty reporting
    fill(20'h00012, 20'h33333, 3'b111, "R6 fill dirty");
    look(20'h00012, 12'h800, 1'b1, "R5 dirty");
    // R11: idle lookup
    step(1'b0, {20'h00012, 12'h0}, 1'b1, 1'b0, '0, '0, '0, 1'b0, "R11 idle");

    // R9: flush, then everything misses
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, '0, 1'b1, "R9 flush");
    look(20'h00005, 12'h0, 1'b0, "R9 flushed miss");

    // R7: fill all slots then wrap
    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 20'h50000 + 20'(i), 3'b110, "R7 fill");
    look(20'h100, 12'h0, 1'b0, "R7 first resident");
    look(20'h100 + 20'(N-1), 12'h0, 1'b0, "R7 last resident");
    fill(20'h200, 20'h60000, 3'b110, "R7 evict");
    look(20'h100, 12'h0, 1'b0, "R7 oldest evicted");
    look(20'h101, 12'h0, 1'b0, "R7 second kept");

    // R8: rewrite resident page, pointer held
    fill(20'h105, 20'h77777, 3'b101, "R8 rewrite");
    look(20'h105, 12'h3C, 1'b0, "R8 new ppn");
    fill(20'h201, 20'h60001, 3'b110, "R8 next alloc");
    look(20'h101, 12'h0, 1'b0, "R8 evicts next oldest");
    look(20'h102, 12'h0, 1'b0, "R8 following kept");
    look(20'h105, 12'h0, 1'b1, "R8 rewritten kept");

    // R10: flush beats refill
    step(1'b0, '0, 1'b0, 1'b1, 20'h300, 20'h12345, 3'b110, 1'b1, "R10 flush+refill");
    look(20'h300, 12'h0, 1'b0, "R10 refill dropped");
    // R9: pointer back to 0 after flush -> first fill lands in slot 0, evicted after N more
    for (int i = 0; i <= N; i++) fill(20'h400 + 20'(i), 20'h40000 + 20'(i), 3'b110, "R9 refill");
    look(20'h400, 12'h0, 1'b0, "R9 slot0 evicted first");
    look(20'h401, 12'h0, 1'b0, "R9 slot1 kept");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [19:0] v, rv2;
      v   = 20'($urandom % 48);
      rv2 = 20'($urandom % 48);
      step(($urandom % 4) != 0, {v, 12'($urandom)}, 1'($urandom),
           ($urandom % 2) == 0, rv2, 20'($urandom), 3'($urandom),
           ($urandom % 97) == 0, "R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule